// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block turns a 5-bit voltage-identification code into a regulator reference and walks the reference toward the requested value one 25 mV unit at a time, so that the output voltage never jumps. A code must be seen on two consecutive switching-cycle ticks before it is accepted. Once accepted, the block waits two further ticks, then makes one unit step every second tick until the reference equals the target. A code accepted while a move is running is handled by direction: if the new target lies on the same side of the present reference, the move carries on with no pause. If it lies on the other side, the move halts and the two-tick wait starts again. The direction is always judged against the reference as it stands at that tick, never against the earlier target.

The reference leaves the block as a 6-bit count of 25 mV units above a 1.100 V base. A soft-start load input copies the decoded code straight into the reference, which sets the starting point after power-up. An enable input freezes the block. The all-ones code means the output is off: it raises the off flag and stops any move.

The controller has three states. ST_IDLE means the reference equals the target, or the output is off. ST_WAIT is the qualification wait after a code is accepted. ST_STEP means the reference is moving. The transitions are as follows. ST_IDLE goes to ST_WAIT when a code is accepted whose target differs from the reference. ST_WAIT goes to ST_STEP after two ticks. ST_STEP goes back to ST_IDLE on the step that reaches the target. ST_STEP goes to ST_WAIT when an accepted code reverses the direction. ST_WAIT goes back to ST_WAIT, restarting its count, when another code is accepted. Any state goes to ST_IDLE in four cases: an accepted code equals the present reference, the off code is accepted, a soft-start load occurs, or enable is low.

Top module: `dvs_ref_stepper`

## Requirements
- R1: A code c from 0 to 30 gives a target of 30 - c units. Code 0 is 30 units (1.850 V) and code 30 is 0 units (1.100 V).
- R2: The all-ones code 31, once accepted, raises off_o, keeps busy_o low and holds ref_o. A later valid code clears off_o when it is accepted.
- R3: Codes are sampled only on ticks. A code that differs from the accepted code is accepted on the second of two consecutive ticks that both see it. A code seen on only one tick is ignored.
- R4: After a code is accepted, ref_o is held for two ticks. The first unit step lands on the fourth tick after acceptance, and later steps land every second tick. A move of k units keeps busy_o high for 2 + 2k ticks.
- R5: ref_o changes by at most one unit per clock, and only on tick clocks or soft-start loads.
- R6: A code accepted during ST_STEP whose target lies in the present direction of travel retargets the move with no pause in the step rhythm.
- R7: A code accepted during ST_STEP whose target lies in the opposite direction from the present ref_o halts the move and restarts the two-tick wait. The direction is judged from the present ref_o, not from the earlier target.
- R8: busy_o rises on the clock after acceptance and falls on the clock whose step makes ref_o equal the target. An accepted code equal to the present ref_o leaves busy_o low. ref_o never changes while busy_o is low, except on a load.
- R9: With en_i high, preload_i loads ref_o with the decoded target of vid_i on the next clock, with no wait and no steps. Loading code 31 sets off_o and leaves ref_o unchanged.
- R10: After reset, ref_o is 0, off_o is 1 and busy_o is 0. While en_i is low the block drops to ST_IDLE, ignores ticks and loads, and holds ref_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| vid_i | input | 5 | Voltage-identification code |
| en_i | input | 1 | Block enable |
| preload_i | input | 1 | Soft-start load of the reference from vid_i |
| ref_o | output | 6 | Reference in 25 mV units above 1.100 V |
| off_o | output | 1 | The accepted code is the off code |
| busy_o | output | 1 | A wait or a move is in progress |

## Verification
The checker watches, on every cycle, that the reference moves by at most one unit and only on ticks or loads, that it stays fixed whenever the block is not busy, that the off flag and busy are never high together, and that a low enable clears busy. The bench covers what those cycle-level rules cannot show on their own. It runs a behavioural reference model and compares all outputs on every clock. Its scenarios measure the exact number of busy ticks a move takes, show that a one-tick glitch is rejected, and show that a same-direction retarget and a reversal judged from the transitional reference each end at the right value.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_STEP = 2'd2
    } dvs_state_e;

endpackage

// File: rtl/dvs_vid_decode.sv
module dvs_vid_decode #(
    parameter int CODE_W = 5,
    parameter int REF_W  = 6
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [REF_W-1:0]  tgt_o,
    output logic              off_o
);
    // Highest valid code maps to unit zero; code zero maps to the top unit.
    localparam int TOP_CODE = (1 << CODE_W) - 2;

    assign off_o = &code_i;
    assign tgt_o = REF_W'(TOP_CODE - int'(code_i));

endmodule

// File: rtl/dvs_vid_detect.sv
module dvs_vid_detect #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] vid_i,
    input  logic [CODE_W-1:0] acc_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= '1;
        else if (en_i && (load_i || tick_i))
            seen_q <= vid_i;
    end

    // A code is qualified when two consecutive ticks observe the same value
    // and that value differs from the one already accepted.
    assign hit_o  = en_i && tick_i && !load_i && (vid_i == seen_q) && (seen_q != acc_i);
    assign code_o = seen_q;

endmodule

// File: rtl/dvs_ref_stepper.sv
module dvs_ref_stepper
    import dvs_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int REF_W      = 6,
    parameter int WAIT_TICKS = 2,
    parameter int STEP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] vid_i,
    input  logic              en_i,
    input  logic              preload_i,
    output logic [REF_W-1:0]  ref_o,
    output logic              off_o,
    output logic              busy_o
);
    localparam int WCNT_W = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
    localparam int PH_W   = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [WCNT_W-1:0] LAST_W = WCNT_W'(WAIT_TICKS - 1);
    localparam logic [PH_W-1:0]   LAST_P = PH_W'(STEP_TICKS - 1);
    localparam logic [CODE_W-1:0] OFF_CODE = '1;

    dvs_state_e        st_q, st_n;
    logic [REF_W-1:0]  ref_q, ref_n, tgt_q, tgt_n, goal;
    logic [CODE_W-1:0] acc_q, acc_n;
    logic [WCNT_W-1:0] wcnt_q, wcnt_n;
    logic [PH_W-1:0]   ph_q, ph_n;
    logic              run;

    logic              hit;
    logic [CODE_W-1:0] hit_code;
    logic [REF_W-1:0]  hit_tgt, pre_tgt;
    logic              hit_off, pre_off;

    dvs_vid_detect #(.CODE_W(CODE_W)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .tick_i (tick_i),
        .load_i (preload_i),
        .vid_i  (vid_i),
        .acc_i  (acc_q),
        .hit_o  (hit),
        .code_o (hit_code)
    );

    dvs_vid_decode #(.CODE_W(CODE_W), .REF_W(REF_W)) u_dec_hit (
        .code_i (hit_code),
        .tgt_o  (hit_tgt),
        .off_o  (hit_off)
    );

    dvs_vid_decode #(.CODE_W(CODE_W), .REF_W(REF_W)) u_dec_pre (
        .code_i (vid_i),
        .tgt_o  (pre_tgt),
        .off_o  (pre_off)
    );

    // Next-state and datapath decisions.
    always_comb begin
        st_n   = st_q;
        ref_n  = ref_q;
        tgt_n  = tgt_q;
        acc_n  = acc_q;
        wcnt_n = wcnt_q;
        ph_n   = ph_q;
        goal   = tgt_q;
        run    = 1'b0;
        if (!en_i) begin
            st_n = ST_IDLE;
        end else if (preload_i) begin
            acc_n = vid_i;
            st_n  = ST_IDLE;
            if (!pre_off) begin
                ref_n = pre_tgt;
                tgt_n = pre_tgt;
            end
        end else if (tick_i) begin
            if (hit) begin
                acc_n = hit_code;
                if (hit_off) begin
                    st_n = ST_IDLE;
                end else begin
                    tgt_n = hit_tgt;
                    if (hit_tgt == ref_q) begin
                        st_n = ST_IDLE;
                    end else if (st_q == ST_STEP &&
                                 ((hit_tgt > ref_q) == (tgt_q > ref_q))) begin
                        goal = hit_tgt;
                        run  = 1'b1;
                    end else begin
                        st_n   = ST_WAIT;
                        wcnt_n = '0;
                    end
                end
            end else begin
                unique case (st_q)
                    ST_IDLE: ;
                    ST_WAIT: begin
                        if (wcnt_q == LAST_W) begin
                            st_n = ST_STEP;
                            ph_n = '0;
                        end else begin
                            wcnt_n = wcnt_q + 1'b1;
                        end
                    end
                    ST_STEP: run = 1'b1;
                    default: st_n = ST_IDLE;
                endcase
            end
            if (run) begin
                if (ph_q == LAST_P) begin
                    ph_n  = '0;
                    ref_n = (goal > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
                    if (ref_n == goal)
                        st_n = ST_IDLE;
                end else begin
                    ph_n = ph_q + 1'b1;
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ref_q  <= '0;
            tgt_q  <= '0;
            acc_q  <= OFF_CODE;
            wcnt_q <= '0;
            ph_q   <= '0;
        end else begin
            st_q   <= st_n;
            ref_q  <= ref_n;
            tgt_q  <= tgt_n;
            acc_q  <= acc_n;
            wcnt_q <= wcnt_n;
            ph_q   <= ph_n;
        end
    end

    // Outputs.
    always_comb begin
        ref_o  = ref_q;
        off_o  = (acc_q == OFF_CODE);
        busy_o = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/dvs_ref_stepper_chk.sv
module dvs_ref_stepper_chk #(
    parameter int REF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             en_i,
    input logic             preload_i,
    input logic [REF_W-1:0] ref_o,
    input logic             off_o,
    input logic             busy_o
);
    localparam logic [REF_W-1:0] ONE = REF_W'(1);

    a_r5_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_i |=> (ref_o == $past(ref_o) || ref_o == $past(ref_o) + ONE ||
                        ref_o == $past(ref_o) - ONE));

    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !preload_i) |=> $stable(ref_o));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !preload_i) |=> $stable(ref_o));

    a_r2_off_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |-> !busy_o);

    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);

endmodule

bind dvs_ref_stepper dvs_ref_stepper_chk #(.REF_W(REF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .en_i      (en_i),
    .preload_i (preload_i),
    .ref_o     (ref_o),
    .off_o     (off_o),
    .busy_o    (busy_o)
);

// File: tb/dvs_ref_stepper_test.sv
module dvs_ref_stepper_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [4:0] vid_i = 5'd31;
    logic       en_i = 1'b0;
    logic       preload_i = 1'b0;
    logic [5:0] ref_o;
    logic       off_o;
    logic       busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int tick_ph = 0;

    // Behavioural model state.
    int m_ref = 0, m_tgt = 0, m_acc = 31, m_s1 = 31, m_mode = 0, m_cnt = 0, m_half = 0;

    always #10 clk = ~clk;

    dvs_ref_stepper uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .vid_i     (vid_i),
        .en_i      (en_i),
        .preload_i (preload_i),
        .ref_o     (ref_o),
        .off_o     (off_o),
        .busy_o    (busy_o)
    );

    // mode: 0 settled, 1 qualifying wait, 2 moving
    always @(posedge clk) begin : model
        int  nt, goal;
        bit  det, run;
        if (!rst_n) begin
            m_ref = 0; m_tgt = 0; m_acc = 31; m_s1 = 31; m_mode = 0; m_cnt = 0; m_half = 0;
        end else if (!en_i) begin
            m_mode = 0;
        end else if (preload_i) begin
            m_acc = vid_i; m_s1 = vid_i; m_mode = 0;
            if (vid_i != 31) begin m_ref = 30 - vid_i; m_tgt = m_ref; end
        end else if (tick_i) begin
            det  = (int'(vid_i) == m_s1) && (m_s1 != m_acc);
            m_s1 = vid_i;
            run  = 0;
            goal = m_tgt;
            if (det) begin
                m_acc = vid_i;
                if (vid_i == 31) m_mode = 0;
                else begin
                    nt = 30 - vid_i;
                    m_tgt = nt;
                    if (nt == m_ref) m_mode = 0;
                    else if (m_mode == 2 && ((nt > m_ref) == (goal > m_ref))) begin
                        goal = nt; run = 1;
                    end else begin
                        m_mode = 1; m_cnt = 0;
                    end
                end
            end else if (m_mode == 1) begin
                if (m_cnt == 1) begin m_mode = 2; m_half = 0; end
                else m_cnt++;
            end else if (m_mode == 2) begin
                run = 1;
            end
            if (run) begin
                if (m_half == 1) begin
                    m_half = 0;
                    m_ref  = m_ref + ((goal > m_ref) ? 1 : -1);
                    if (m_ref == goal) m_mode = 0;
                end else begin
                    m_half = 1;
                end
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: compare against the model after the edge, then drive the next tick.
    task automatic step();
        @(negedge clk);
        if (int'(ref_o) != m_ref)
            check(0, "R5/R1 cycle ref", ref_o, m_ref);
        else if (busy_o != (m_mode != 0))
            check(0, "R8/R4 cycle busy", busy_o, m_mode != 0);
        else if (off_o != (m_acc == 31))
            check(0, "R2 cycle off", off_o, m_acc == 31);
        else
            check(1, "cycle", 0, 0);
        tick_i  = (tick_ph == 0);
        tick_ph = (tick_ph + 1) % 4;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_until(int v, int lim);
        for (int i = 0; i < lim && int'(ref_o) != v; i++) step();
    endtask

    task automatic load(int code);
        vid_i = 5'(code);
        preload_i = 1'b1;
        step();
        preload_i = 1'b0;
        run(2);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin : stim
        int busy_clks;
        run(4);
        check(ref_o == 0, "R10 reset ref", ref_o, 0);
        check(off_o == 1, "R10 reset off", off_o, 1);
        check(busy_o == 0, "R10 reset busy", busy_o, 0);
        rst_n = 1'b1;
        en_i  = 1'b1;
        run(3);

        // R1 / R9: direct loads
        load(30); check(ref_o == 0 && off_o == 0, "R1 code 30", ref_o, 0);
        load(0);  check(ref_o == 30, "R1 code 0", ref_o, 30);
        load(20); check(ref_o == 10 && busy_o == 0, "R9 load code 20", ref_o, 10);

        // R4 / R8: move of four units, busy for 2 + 2*4 ticks of 4 clocks
        vid_i = 5'd16;
        busy_clks = 0;
        for (int i = 0; i < 120; i++) begin
            step();
            if (busy_o) busy_clks++;
        end
        check(busy_clks == 40, "R4 busy duration", busy_clks, 40);
        check(ref_o == 14 && busy_o == 0, "R8 settled at target", ref_o, 14);

        // R3: a code seen on one tick only is ignored
        vid_i = 5'd2;
        run(4);
        vid_i = 5'd16;
        run(40);
        check(ref_o == 14 && busy_o == 0, "R3 glitch ignored", ref_o, 14);

        // R6: same-direction retarget mid-move
        vid_i = 5'd10;
        run_until(16, 400);
        vid_i = 5'd6;
        run(200);
        check(ref_o == 24, "R6 same-direction retarget", ref_o, 24);

        // R7: reversal mid-move
        vid_i = 5'd14;
        run_until(21, 400);
        vid_i = 5'd0;
        run(200);
        check(ref_o == 30, "R7 reversal", ref_o, 30);

        // R7: direction judged from transitional reference
        vid_i = 5'd20;
        run_until(16, 400);
        vid_i = 5'd12;
        run(200);
        check(ref_o == 18, "R7 transitional direction", ref_o, 18);

        // R2: off code
        vid_i = 5'd31;
        run(40);
        check(off_o == 1 && busy_o == 0 && ref_o == 18, "R2 off holds ref", ref_o, 18);
        vid_i = 5'd20;
        run(200);
        check(off_o == 0 && ref_o == 10, "R2 leave off", ref_o, 10);

        // R10: disabled block ignores codes and loads
        en_i = 1'b0;
        vid_i = 5'd0;
        run(40);
        preload_i = 1'b1; run(1); preload_i = 1'b0;
        run(20);
        check(ref_o == 10 && busy_o == 0, "R10 disabled holds", ref_o, 10);
        en_i = 1'b1;
        run(200);
        check(ref_o == 30, "R10 resumes after enable", ref_o, 30);

        // R8: accepted code equal to the present reference leaves busy low
        vid_i = 5'd0; load(4);
        vid_i = 5'd4;
        run(40);
        check(busy_o == 0 && ref_o == 26, "R8 equal code idle", ref_o, 26);

        finish_up();
    end

endmodule